// File: doc/BRIEF.md
# Bus-grant DMA controller

A single-channel direct memory access engine that moves a block of words between system memory and one peripheral without the processor doing the copying. Software programs a start address, a word count and a control word through a small register port. Once the channel is armed, a request from the peripheral makes the controller ask the processor for the bus. It drives nothing until the grant comes back. It then places successive addresses on the bus together with a memory strobe and an acknowledge to the peripheral. The transfer is fly-by: the data itself passes directly between memory and the peripheral.

Two transfer styles are offered. In block mode the controller keeps the bus and moves one word per clock until the count is exhausted. In steal mode it moves exactly one word per grant. During that single cycle it pulls the processor clock enable low, then hands the bus back before it asks again. When the last word has moved, a sticky done flag is raised and the bus is released. A status read clears the flag.

Top module: `dmac_top`

## Requirements
- R1: After reset, bus_req, bus_own, xfer_ack, mem_rd and mem_wr are low, cpu_clk_en is high, and all four registers read as zero.
- R2: reg_sel chooses the register. 0 is the address, 1 is the remaining count (zero-extended), 2 is control and 3 is status. Control bit 0 sets the direction (0 memory to peripheral, 1 peripheral to memory), bit 1 sets the mode (0 block, 1 steal) and bit 2 arms the channel. Status bit 0 is done, bit 1 is busy and bit 2 is armed. Writes to status have no effect.
- R3: With the channel armed, the count nonzero and xfer_req high, bus_req rises on the next clock. bus_own, xfer_ack and the strobes stay low until bus_gnt has been sampled high, and they rise in the cycle after that sample.
- R4: In every transfer cycle, bus_own and xfer_ack are high and bus_addr equals the current address. mem_rd is high when the direction is 0 and mem_wr is high when the direction is 1. Outside transfer cycles bus_addr is zero.
- R5: Each completed word increments the address register by one and decrements the count register by one.
- R6: In block mode the transfer cycles are consecutive, with no idle cycle between them, until the count reaches zero.
- R7: In steal mode each granted word takes one cycle, and cpu_clk_en is low in exactly that cycle and in no other. bus_own is low for at least one cycle between two words.
- R8: When the last word completes, done is set and arm is cleared, and on the next cycle bus_req and xfer_ack are low.
- R9: A status read clears done. If the last word completes in the same cycle as a status read, the read returns done=0 and done is still set afterwards.
- R10: While busy, writes to the address, count and control registers are ignored.
- R11: If bus_gnt is low during a transfer cycle, the word in that cycle is not counted. bus_own falls on the next cycle while bus_req stays high, and the transfer resumes once the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears done) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data, combinational |
| xfer_req | input | 1 | Transfer request from the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| xfer_ack | output | 1 | Acknowledge to the peripheral during a transfer cycle |
| bus_own | output | 1 | Controller drives the system bus |
| bus_addr | output | ADDR_W | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| cpu_clk_en | output | 1 | Processor clock enable, low for one cycle per stolen word |

## Verification
The last word can complete, setting done, in the same cycle that software reads status, which clears it. The bench arms a one-word transfer and waits at the falling edge until bus_own first shows high. Within that same transfer cycle it raises a status read. It expects the returned value to show done low while busy and armed are high. It then expects a follow-up read to return done alone, and a third read to return zero.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_MOVE = 2'd2,
        ST_GAP  = 2'd3
    } dmac_state_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_STAT = 2'd3
    } dmac_sel_e;

    localparam int CTRL_DIR   = 0;
    localparam int CTRL_STEAL = 1;
    localparam int CTRL_ARM   = 2;
    localparam int STAT_DONE  = 0;
    localparam int STAT_BUSY  = 1;
    localparam int STAT_ARMED = 2;

    typedef struct packed {
        logic arm;
        logic steal;
        logic to_mem;
    } dmac_ctrl_t;

    typedef struct packed {
        logic req;
        logic own;
        logic ack;
        logic rd;
        logic wr;
        logic clk_en;
    } dmac_bus_t;

    function automatic dmac_bus_t bus_decode(dmac_state_e st, dmac_ctrl_t c);
        dmac_bus_t b;
        b.req    = (st == ST_REQ) || (st == ST_MOVE);
        b.own    = (st == ST_MOVE);
        b.ack    = (st == ST_MOVE);
        b.rd     = (st == ST_MOVE) && !c.to_mem;
        b.wr     = (st == ST_MOVE) && c.to_mem;
        b.clk_en = !((st == ST_MOVE) && c.steal);
        return b;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              last,
    output logic [ADDR_W-1:0] cur_addr,
    output dmac_ctrl_t        ctrl,
    output logic              cnt_nz,
    output logic              cnt_one
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    dmac_ctrl_t        ctrl_q;
    logic              done_q;
    logic              wr_ok;
    logic              finish;

    assign wr_ok  = reg_wr && !busy;
    assign finish = step && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end else if (wr_ok && reg_sel == SEL_ADDR) begin
            addr_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (wr_ok && reg_sel == SEL_CNT) begin
            cnt_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (finish) begin
            ctrl_q.arm <= 1'b0;
        end else if (wr_ok && reg_sel == SEL_CTRL) begin
            ctrl_q.to_mem <= reg_wdata[CTRL_DIR];
            ctrl_q.steal  <= reg_wdata[CTRL_STEAL];
            ctrl_q.arm    <= reg_wdata[CTRL_ARM];
        end
    end

    // set has priority over the clear-on-read
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (reg_rd && reg_sel == SEL_STAT) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR: reg_rdata = addr_q;
            SEL_CNT:  reg_rdata[CNT_W-1:0] = cnt_q;
            SEL_CTRL: begin
                reg_rdata[CTRL_DIR]   = ctrl_q.to_mem;
                reg_rdata[CTRL_STEAL] = ctrl_q.steal;
                reg_rdata[CTRL_ARM]   = ctrl_q.arm;
            end
            default: begin
                reg_rdata[STAT_DONE]  = done_q;
                reg_rdata[STAT_BUSY]  = busy;
                reg_rdata[STAT_ARMED] = ctrl_q.arm;
            end
        endcase
    end

    assign cur_addr = addr_q;
    assign ctrl     = ctrl_q;
    assign cnt_nz   = |cnt_q;
    assign cnt_one  = (cnt_q == CNT_W'(1));

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr_q == $past(addr_q) + ADDR_W'(1)) && (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_sel == SEL_ADDR && !step) |=> (addr_q == $past(addr_q))); // R10

    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_sel == SEL_CNT && !step) |=> (cnt_q == $past(cnt_q))); // R10

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        finish |=> (done_q && !ctrl_q.arm)); // R8

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == SEL_STAT && !finish) |=> !done_q); // R9

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dmac_ctrl_t ctrl,
    input  logic       cnt_nz,
    input  logic       cnt_one,
    input  logic       xfer_req,
    input  logic       bus_gnt,
    output dmac_bus_t  bus,
    output logic       busy,
    output logic       step,
    output logic       last
);

    dmac_state_e state_q;
    dmac_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (ctrl.arm && xfer_req && cnt_nz) state_d = ST_REQ;
            ST_REQ:  if (bus_gnt) state_d = ST_MOVE;
            ST_MOVE: begin
                if (!bus_gnt)        state_d = ST_REQ;
                else if (cnt_one)    state_d = ST_IDLE;
                else if (ctrl.steal) state_d = ST_GAP;
                else                 state_d = ST_MOVE;
            end
            default: state_d = xfer_req ? ST_REQ : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign bus  = bus_decode(state_q, ctrl);
    assign busy = (state_q != ST_IDLE);
    assign step = (state_q == ST_MOVE) && bus_gnt;
    assign last = step && cnt_one;

    AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(bus.own) |-> $past(bus_gnt) && $past(bus.req)); // R3

    AST_STEAL_ONE: assert property (@(posedge clk) disable iff (rst)
        !bus.clk_en |=> bus.clk_en); // R7

    AST_STEAL_OWNED: assert property (@(posedge clk) disable iff (rst)
        !bus.clk_en |-> bus.own); // R7

    AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_one && !ctrl.steal) |=> bus.own); // R6

    AST_LOST_GRANT: assert property (@(posedge clk) disable iff (rst)
        (bus.own && !bus_gnt) |=> (!bus.own && bus.req)); // R11

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        last |=> (!bus.req && !bus.ack)); // R8

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              xfer_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              xfer_ack,
    output logic              bus_own,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              cpu_clk_en
);

    dmac_ctrl_t        ctrl;
    dmac_bus_t         bus;
    logic [ADDR_W-1:0] cur_addr;
    logic              cnt_nz;
    logic              cnt_one;
    logic              busy;
    logic              step;
    logic              last;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .step      (step),
        .last      (last),
        .cur_addr  (cur_addr),
        .ctrl      (ctrl),
        .cnt_nz    (cnt_nz),
        .cnt_one   (cnt_one)
    );

    dmac_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .cnt_nz   (cnt_nz),
        .cnt_one  (cnt_one),
        .xfer_req (xfer_req),
        .bus_gnt  (bus_gnt),
        .bus      (bus),
        .busy     (busy),
        .step     (step),
        .last     (last)
    );

    assign bus_req    = bus.req;
    assign bus_own    = bus.own;
    assign xfer_ack   = bus.ack;
    assign mem_rd     = bus.rd;
    assign mem_wr     = bus.wr;
    assign cpu_clk_en = bus.clk_en;
    assign bus_addr   = bus.own ? cur_addr : '0;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        bus_own |-> $onehot({mem_rd, mem_wr}) && xfer_ack); // R4

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_own |-> (bus_addr == '0) && !mem_rd && !mem_wr); // R4

endmodule

// File: tb/sim_dmac_top.sv
module sim_dmac_top;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        reg_sel = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_wdata = '0;
    logic [ADDR_W-1:0] reg_rdata;
    logic              xfer_req = 1'b0;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              xfer_ack;
    logic              bus_own;
    logic [ADDR_W-1:0] bus_addr;
    logic              mem_rd;
    logic              mem_wr;
    logic              cpu_clk_en;
    logic              grant_on = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // processor stub: grants one clock after the request
    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= grant_on && bus_req;
    end

    dmac_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_req   (xfer_req),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .xfer_ack   (xfer_ack),
        .bus_own    (bus_own),
        .bus_addr   (bus_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .cpu_clk_en (cpu_clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [ADDR_W-1:0] data);
        reg_sel = sel; reg_rd = 1'b1;
        #1 data = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic test_reset();
        logic [ADDR_W-1:0] v;
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 bus_own/ack/strobes", 32'({bus_own, xfer_ack, mem_rd, mem_wr}), 0);
        chk("R1 cpu_clk_en", 32'(cpu_clk_en), 1);
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), v);
            chk("R1 register zero", 32'(v), 0);
        end
        reg_write(2'd3, 16'h0007);
        reg_read(2'd3, v);
        chk("R2 status write ignored", 32'(v), 0);
    endtask

    task automatic test_block();
        logic [ADDR_W-1:0] v;
        int nbus = 0; int bad_addr = 0; int bad_strobe = 0; int gaps = 0; int inh = 0;
        bit started = 0; bit ended = 0;
        reg_write(2'd0, 16'h0100);
        reg_write(2'd1, 16'd4);
        reg_write(2'd2, 16'h0004);
        xfer_req = 1'b1;
        @(negedge clk);
        chk("R3 request raised", 32'(bus_req), 1);
        chk("R3 no bus before grant", 32'(bus_own), 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!cpu_clk_en) inh++;
            if (bus_own) begin
                if (ended) gaps++;
                started = 1;
                if (bus_addr !== 16'h0100 + 16'(nbus)) bad_addr++;
                if (!(mem_rd && !mem_wr && xfer_ack)) bad_strobe++;
                nbus++;
            end else if (started) ended = 1;
        end
        xfer_req = 1'b0;
        chk("R6 block word count", 32'(nbus), 4);
        chk("R6 block no gaps", 32'(gaps), 0);
        chk("R4 address sequence", 32'(bad_addr), 0);
        chk("R4 read strobe and ack", 32'(bad_strobe), 0);
        chk("R7 no clock steal in block mode", 32'(inh), 0);
        chk("R8 bus released", 32'({bus_req, xfer_ack}), 0);
        reg_read(2'd0, v); chk("R5 address advanced", 32'(v), 32'h0104);
        reg_read(2'd1, v); chk("R5 count exhausted", 32'(v), 0);
        reg_read(2'd2, v); chk("R8 arm cleared", 32'(v), 0);
        reg_read(2'd3, v); chk("R8 done set", 32'(v), 1);
        reg_read(2'd3, v); chk("R9 done cleared by read", 32'(v), 0);
    endtask

    task automatic test_steal();
        logic [ADDR_W-1:0] v;
        int nbus = 0; int inh = 0; int stray = 0; int back2back = 0; int bad_strobe = 0;
        bit prev = 0;
        reg_write(2'd0, 16'h0200);
        reg_write(2'd1, 16'd3);
        reg_write(2'd2, 16'h0007);
        xfer_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cpu_clk_en) begin
                inh++;
                if (!bus_own) stray++;
            end
            if (bus_own) begin
                if (prev) back2back++;
                if (!(mem_wr && !mem_rd)) bad_strobe++;
                if (bus_addr !== 16'h0200 + 16'(nbus)) bad_strobe++;
                nbus++;
            end
            prev = bus_own;
        end
        xfer_req = 1'b0;
        chk("R7 steal word count", 32'(nbus), 3);
        chk("R7 one inhibit cycle per word", 32'(inh), 3);
        chk("R7 inhibit only while owning bus", 32'(stray), 0);
        chk("R7 bus released between words", 32'(back2back), 0);
        chk("R4 write strobe and address", 32'(bad_strobe), 0);
        reg_read(2'd0, v); chk("R5 steal address advanced", 32'(v), 32'h0203);
        reg_read(2'd3, v); chk("R8 steal done", 32'(v), 1);
        reg_read(2'd3, v); chk("R9 steal done cleared", 32'(v), 0);
    endtask

    task automatic test_lock();
        logic [ADDR_W-1:0] v;
        grant_on = 1'b0;
        reg_write(2'd0, 16'h0300);
        reg_write(2'd1, 16'd2);
        reg_write(2'd2, 16'h0004);
        xfer_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 held off without grant", 32'({bus_req, bus_own}), 32'b10);
        reg_read(2'd3, v); chk("R2 status busy and armed", 32'(v), 32'h6);
        reg_write(2'd0, 16'h0ABC);
        reg_write(2'd1, 16'd9);
        reg_write(2'd2, 16'h0003);
        grant_on = 1'b1;
        repeat (20) @(negedge clk);
        xfer_req = 1'b0;
        reg_read(2'd0, v); chk("R10 address write ignored", 32'(v), 32'h0302);
        reg_read(2'd1, v); chk("R10 count write ignored", 32'(v), 0);
        reg_read(2'd2, v); chk("R10 control write ignored", 32'(v), 0);
        reg_read(2'd3, v); chk("R8 locked transfer done", 32'(v), 1);
    endtask

    task automatic test_withdraw();
        logic [ADDR_W-1:0] v;
        int nbus = 0;
        reg_write(2'd0, 16'h0400);
        reg_write(2'd1, 16'd6);
        reg_write(2'd2, 16'h0004);
        xfer_req = 1'b1;
        for (int i = 0; i < 20 && nbus < 2; i++) begin
            @(negedge clk);
            if (bus_own) nbus++;
        end
        grant_on = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 bus released after grant loss", 32'(bus_own), 0);
        chk("R11 request still pending", 32'(bus_req), 1);
        reg_read(2'd1, v); chk("R11 lost cycle not counted", 32'(v), 4);
        grant_on = 1'b1;
        repeat (25) @(negedge clk);
        xfer_req = 1'b0;
        reg_read(2'd0, v); chk("R11 resumed to end address", 32'(v), 32'h0406);
        reg_read(2'd1, v); chk("R11 count exhausted", 32'(v), 0);
        reg_read(2'd3, v); chk("R11 done after resume", 32'(v), 1);
    endtask

    task automatic test_collision();
        logic [ADDR_W-1:0] v;
        reg_write(2'd0, 16'h0500);
        reg_write(2'd1, 16'd1);
        reg_write(2'd2, 16'h0004);
        xfer_req = 1'b1;
        for (int i = 0; i < 20 && !bus_own; i++) @(negedge clk);
        chk("R4 single word on bus", 32'(bus_addr), 32'h0500);
        reg_read(2'd3, v);
        xfer_req = 1'b0;
        chk("R9 colliding read sees old done", 32'(v), 32'h6);
        reg_read(2'd3, v); chk("R9 set wins over clear", 32'(v), 1);
        reg_read(2'd3, v); chk("R9 cleared on next read", 32'(v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_block();
        test_steal();
        test_lock();
        test_withdraw();
        test_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule